// File: doc/BRIEF.md
# Branch Target Selection Logic

This block turns the facts gathered about one fetched branch into a next-PC prediction. Its inputs are the branch's class flags (unconditional, call, return, direct), the branch PC, the direction predictor's verdict, the target buffer's hit flag and stored target, and the top entry of the return address stack. From these it produces the predicted direction and target, push and pop requests for the return stack, a request that tells the direction predictor to correct itself, and the fields the fetch stage writes into the new speculative history record.

Instructions are a fixed 4 bytes, so the fall-through address is PC + 4. Indirect branches go through the target buffer exactly like direct ones. A synthesis parameter selects whether an unconditional direct call takes its target from the immediate offset carried with the instruction (PC + offset) instead of from the target buffer.

The results are registered. A small state machine has two states: `S_IDLE` (no result on the outputs) and `S_ISSUE` (a result is on the outputs for one cycle). The transition `IDLE_TO_ISSUE` or `ISSUE_TO_ISSUE` is taken on any clock edge where `in_valid` is high; `ISSUE_TO_IDLE` or `IDLE_TO_IDLE` is taken when it is low.

Top module: `brtgt_select`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it, `out_valid`, `ras_push`, `ras_pop` and `dir_fix` are 0.
- R2: `out_valid` is 1 in exactly the cycle after a cycle with `in_valid` high; in every cycle with `out_valid` low, `ras_push`, `ras_pop` and `dir_fix` are 0.
- R3: A branch with `in_uncond`=1 is treated as taken whatever `dir_taken` says; any other branch follows `dir_taken` before the target checks below.
- R4: A taken return (`in_ret`=1, which wins over `in_call`) gives `out_taken`=1, `out_target`=`ras_top_val`, `ras_pop`=1, `rec_used_ras`=1, and records `ras_top_idx` and `ras_top_val` in `rec_ras_idx`/`rec_ras_val`; the target buffer is not consulted.
- R5: A taken call with a target buffer hit gives `out_taken`=1, `out_target`=`tb_target`, `ras_push`=1 with `ras_push_val` equal to the branch PC, and `rec_was_call`=`rec_pushed`=1.
- R6: A taken non-call, non-return branch with a target buffer hit gives `out_taken`=1 and `out_target`=`tb_target`, with no stack request.
- R7: A taken non-call, non-return branch that misses in the target buffer gives `out_taken`=0, `out_target`=PC+4 and `dir_fix`=1.
- R8: A taken conditional call that misses gives `ras_push`=1 and `ras_pop`=1 in the same cycle (the push is undone, net stack unchanged), `rec_was_call`=1, `rec_pushed`=0, `out_taken`=0 and `out_target`=PC+4.
- R9: A not-taken branch gives `out_target`=PC+4 with no stack request and no `dir_fix`; `rec_was_ret` copies `in_ret` for every branch, taken or not.
- R10: With `IMM_CALL_EN`=1, an unconditional direct call gives `out_taken`=1 and `out_target`=PC+`in_imm_off` whether or not the target buffer hits, and pushes as in R5.
- R11: An unconditional call that misses and does not take the immediate path stays taken with `out_target`=PC+4 and keeps its push (`ras_push`=1, `rec_pushed`=1, `ras_pop`=0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A branch is presented this cycle |
| in_pc | input | AW | Branch PC |
| in_uncond | input | 1 | Unconditional control transfer |
| in_call | input | 1 | Branch is a call |
| in_ret | input | 1 | Branch is a return |
| in_direct | input | 1 | Target is encoded in the instruction |
| in_imm_off | input | AW | Encoded target offset (two's complement) |
| dir_taken | input | 1 | Direction predictor verdict |
| tb_hit | input | 1 | Target buffer holds an entry for the PC |
| tb_target | input | AW | Target buffer target |
| ras_top_val | input | AW | Return stack top value |
| ras_top_idx | input | IW | Return stack top index |
| out_valid | output | 1 | Prediction on the outputs this cycle |
| out_taken | output | 1 | Predicted taken |
| out_target | output | AW | Predicted next PC |
| ras_push | output | 1 | Push request to the return stack |
| ras_push_val | output | AW | Value to push (branch PC) |
| ras_pop | output | 1 | Pop request (after the push when both are set) |
| dir_fix | output | 1 | Direction predictor must record not taken |
| rec_was_call | output | 1 | History record: branch is a call |
| rec_pushed | output | 1 | History record: push stands |
| rec_was_ret | output | 1 | History record: branch is a return |
| rec_used_ras | output | 1 | History record: target came from the stack |
| rec_ras_idx | output | IW | History record: stack index used |
| rec_ras_val | output | AW | History record: stack value used |

## Verification
Every result is due exactly one clock edge after the cycle its branch was presented, and the strobes drop in the cycle after a cycle without a branch. The bench drives each branch just after a falling edge, computes the expected result from the requirements at that moment, and compares it at the next falling edge, one rising edge later, on every clock including the idle ones. Directed branches cover each path (return, call hit, immediate call, the three kinds of miss, not taken), then a long stretch of random branches with idle gaps exercises back-to-back and isolated issues.

// File: rtl/brtgt_pkg.sv
package brtgt_pkg;

    // Class flags of one branch
    typedef struct packed {
        logic uncond;
        logic call;
        logic ret;
        logic direct;
    } br_class_t;

    // Which path produced the prediction
    typedef enum logic [2:0] {
        K_SEQ       = 3'd0,  // predicted not taken
        K_RAS       = 3'd1,  // taken return
        K_IMM       = 3'd2,  // unconditional direct call, immediate target
        K_TB        = 3'd3,  // taken, target buffer hit
        K_MISS_FIX  = 3'd4,  // miss on plain branch, direction corrected
        K_MISS_UNDO = 3'd5,  // miss on conditional call, push undone
        K_MISS_KEEP = 3'd6   // miss on unconditional call, push kept
    } sel_kind_t;

    // Output state machine
    typedef enum logic {
        S_IDLE  = 1'b0,
        S_ISSUE = 1'b1
    } out_state_t;

endpackage

// File: rtl/brtgt_next_pc.sv
module brtgt_next_pc #(
    parameter int AW       = 32,
    parameter int INST_BYTES = 4
) (
    input  logic [AW-1:0] pc,
    input  logic [AW-1:0] imm_off,
    output logic [AW-1:0] seq_pc,
    output logic [AW-1:0] imm_pc
);
    localparam logic [AW-1:0] STEP = AW'(INST_BYTES);

    always_comb begin
        seq_pc = pc + STEP;
        imm_pc = pc + imm_off;
    end
endmodule

// File: rtl/brtgt_decide.sv
module brtgt_decide
    import brtgt_pkg::*;
#(
    parameter int AW          = 32,
    parameter int IW          = 4,
    parameter bit IMM_CALL_EN = 1'b1
) (
    input  br_class_t      cls,
    input  logic           dir_taken,
    input  logic           tb_hit,
    input  logic [AW-1:0]  tb_target,
    input  logic [AW-1:0]  ras_top_val,
    input  logic [IW-1:0]  ras_top_idx,
    input  logic [AW-1:0]  seq_pc,
    input  logic [AW-1:0]  imm_pc,
    output sel_kind_t      kind,
    output logic           taken,
    output logic [AW-1:0]  target,
    output logic           push,
    output logic           pop,
    output logic           fix,
    output logic           was_call,
    output logic           pushed,
    output logic           was_ret,
    output logic           used_ras,
    output logic [IW-1:0]  ras_idx,
    output logic [AW-1:0]  ras_val
);
    logic taken_raw;
    logic use_imm;

    // Variant: immediate-target path for unconditional direct calls
    generate
        if (IMM_CALL_EN) begin : g_imm
            assign use_imm = cls.call & cls.uncond & cls.direct;
        end else begin : g_no_imm
            assign use_imm = 1'b0;
        end
    endgenerate

    assign taken_raw = cls.uncond | dir_taken;

    // Path selection, in priority order
    always_comb begin
        if (!taken_raw)        kind = K_SEQ;
        else if (cls.ret)      kind = K_RAS;
        else if (use_imm)      kind = K_IMM;
        else if (tb_hit)       kind = K_TB;
        else if (!cls.call)    kind = K_MISS_FIX;
        else if (!cls.uncond)  kind = K_MISS_UNDO;
        else                   kind = K_MISS_KEEP;
    end

    // Outputs per path
    always_comb begin
        taken    = 1'b0;
        target   = seq_pc;
        push     = 1'b0;
        pop      = 1'b0;
        fix      = 1'b0;
        was_call = 1'b0;
        pushed   = 1'b0;
        was_ret  = cls.ret;
        used_ras = 1'b0;
        ras_idx  = '0;
        ras_val  = '0;
        unique case (kind)
            K_SEQ: begin
                taken = 1'b0;
            end
            K_RAS: begin
                taken    = 1'b1;
                target   = ras_top_val;
                pop      = 1'b1;
                used_ras = 1'b1;
                ras_idx  = ras_top_idx;
                ras_val  = ras_top_val;
            end
            K_IMM: begin
                taken    = 1'b1;
                target   = imm_pc;
                push     = 1'b1;
                was_call = 1'b1;
                pushed   = 1'b1;
            end
            K_TB: begin
                taken    = 1'b1;
                target   = tb_target;
                push     = cls.call;
                was_call = cls.call;
                pushed   = cls.call;
            end
            K_MISS_FIX: begin
                taken = 1'b0;
                fix   = 1'b1;
            end
            K_MISS_UNDO: begin
                taken    = 1'b0;
                push     = 1'b1;
                pop      = 1'b1;
                was_call = 1'b1;
                pushed   = 1'b0;
            end
            K_MISS_KEEP: begin
                taken    = 1'b1;
                push     = 1'b1;
                was_call = 1'b1;
                pushed   = 1'b1;
            end
            default: begin
                taken = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/brtgt_select.sv
module brtgt_select
    import brtgt_pkg::*;
#(
    parameter int AW          = 32,
    parameter int IW          = 4,
    parameter int INST_BYTES  = 4,
    parameter bit IMM_CALL_EN = 1'b1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           in_valid,
    input  logic [AW-1:0]  in_pc,
    input  logic           in_uncond,
    input  logic           in_call,
    input  logic           in_ret,
    input  logic           in_direct,
    input  logic [AW-1:0]  in_imm_off,
    input  logic           dir_taken,
    input  logic           tb_hit,
    input  logic [AW-1:0]  tb_target,
    input  logic [AW-1:0]  ras_top_val,
    input  logic [IW-1:0]  ras_top_idx,
    output logic           out_valid,
    output logic           out_taken,
    output logic [AW-1:0]  out_target,
    output logic           ras_push,
    output logic [AW-1:0]  ras_push_val,
    output logic           ras_pop,
    output logic           dir_fix,
    output logic           rec_was_call,
    output logic           rec_pushed,
    output logic           rec_was_ret,
    output logic           rec_used_ras,
    output logic [IW-1:0]  rec_ras_idx,
    output logic [AW-1:0]  rec_ras_val
);
    br_class_t     cls;
    logic [AW-1:0] seq_pc, imm_pc;
    sel_kind_t     kind;
    logic          d_taken, d_push, d_pop, d_fix;
    logic          d_was_call, d_pushed, d_was_ret, d_used_ras;
    logic [AW-1:0] d_target, d_ras_val;
    logic [IW-1:0] d_ras_idx;

    out_state_t state_q, state_d;

    assign cls = '{uncond: in_uncond, call: in_call, ret: in_ret, direct: in_direct};

    brtgt_next_pc #(.AW(AW), .INST_BYTES(INST_BYTES)) u_npc (
        .pc      (in_pc),
        .imm_off (in_imm_off),
        .seq_pc  (seq_pc),
        .imm_pc  (imm_pc)
    );

    brtgt_decide #(.AW(AW), .IW(IW), .IMM_CALL_EN(IMM_CALL_EN)) u_dec (
        .cls         (cls),
        .dir_taken   (dir_taken),
        .tb_hit      (tb_hit),
        .tb_target   (tb_target),
        .ras_top_val (ras_top_val),
        .ras_top_idx (ras_top_idx),
        .seq_pc      (seq_pc),
        .imm_pc      (imm_pc),
        .kind        (kind),
        .taken       (d_taken),
        .target      (d_target),
        .push        (d_push),
        .pop         (d_pop),
        .fix         (d_fix),
        .was_call    (d_was_call),
        .pushed      (d_pushed),
        .was_ret     (d_was_ret),
        .used_ras    (d_used_ras),
        .ras_idx     (d_ras_idx),
        .ras_val     (d_ras_val)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  state_d = in_valid ? S_ISSUE : S_IDLE;   // IDLE_TO_ISSUE / IDLE_TO_IDLE
            S_ISSUE: state_d = in_valid ? S_ISSUE : S_IDLE;   // ISSUE_TO_ISSUE / ISSUE_TO_IDLE
            default: state_d = S_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    assign out_valid = (state_q == S_ISSUE);

    // Output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_taken    <= 1'b0;
            out_target   <= '0;
            ras_push     <= 1'b0;
            ras_push_val <= '0;
            ras_pop      <= 1'b0;
            dir_fix      <= 1'b0;
            rec_was_call <= 1'b0;
            rec_pushed   <= 1'b0;
            rec_was_ret  <= 1'b0;
            rec_used_ras <= 1'b0;
            rec_ras_idx  <= '0;
            rec_ras_val  <= '0;
        end else if (state_d == S_ISSUE) begin
            out_taken    <= d_taken;
            out_target   <= d_target;
            ras_push     <= d_push;
            ras_push_val <= in_pc;
            ras_pop      <= d_pop;
            dir_fix      <= d_fix;
            rec_was_call <= d_was_call;
            rec_pushed   <= d_pushed;
            rec_was_ret  <= d_was_ret;
            rec_used_ras <= d_used_ras;
            rec_ras_idx  <= d_ras_idx;
            rec_ras_val  <= d_ras_val;
        end else begin
            ras_push <= 1'b0;
            ras_pop  <= 1'b0;
            dir_fix  <= 1'b0;
        end
    end
endmodule

// File: rtl/brtgt_select_chk.sv
module brtgt_select_chk #(
    parameter int AW         = 32,
    parameter int INST_BYTES = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic [AW-1:0] in_pc,
    input logic          in_uncond,
    input logic          in_ret,
    input logic          dir_taken,
    input logic          out_valid,
    input logic          out_taken,
    input logic [AW-1:0] out_target,
    input logic          ras_push,
    input logic [AW-1:0] ras_push_val,
    input logic          ras_pop,
    input logic          dir_fix,
    input logic          rec_pushed,
    input logic          rec_used_ras,
    input logic [AW-1:0] rec_ras_val
);
    a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    a_r2_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    a_r2_quiet_strobes: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (!ras_push && !ras_pop && !dir_fix));
    a_r3_uncond_ret_taken: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_uncond && in_ret) |=> out_taken);
    a_r4_ras_target: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && rec_used_ras) |-> (ras_pop && out_taken && out_target == rec_ras_val));
    a_r5_push_own_pc: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && rec_pushed == rec_pushed) |=> (!(ras_push && !ras_pop) || ras_push_val == $past(in_pc)));
    a_r7_fix_not_taken: assert property (@(posedge clk) disable iff (!rst_n)
        dir_fix |-> (!out_taken && !ras_push && !ras_pop));
    a_r8_undo_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && ras_push && ras_pop) |-> (!rec_pushed && !out_taken));
    a_r9_not_taken_seq: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_uncond && !dir_taken) |=>
            (!out_taken && !ras_push && !ras_pop && !dir_fix &&
             out_target == $past(in_pc) + AW'(INST_BYTES)));
endmodule

bind brtgt_select brtgt_select_chk #(.AW(AW), .INST_BYTES(INST_BYTES)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .in_pc        (in_pc),
    .in_uncond    (in_uncond),
    .in_ret       (in_ret),
    .dir_taken    (dir_taken),
    .out_valid    (out_valid),
    .out_taken    (out_taken),
    .out_target   (out_target),
    .ras_push     (ras_push),
    .ras_push_val (ras_push_val),
    .ras_pop      (ras_pop),
    .dir_fix      (dir_fix),
    .rec_pushed   (rec_pushed),
    .rec_used_ras (rec_used_ras),
    .rec_ras_val  (rec_ras_val)
);

// File: tb/brtgt_select_tb.sv
module brtgt_select_tb;
    localparam int AW = 32;
    localparam int IW = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 0, in_uncond = 0, in_call = 0, in_ret = 0, in_direct = 0;
    logic dir_taken = 0, tb_hit = 0;
    logic [AW-1:0] in_pc = '0, in_imm_off = '0, tb_target = '0, ras_top_val = '0;
    logic [IW-1:0] ras_top_idx = '0;
    logic out_valid, out_taken, ras_push, ras_pop, dir_fix;
    logic rec_was_call, rec_pushed, rec_was_ret, rec_used_ras;
    logic [AW-1:0] out_target, ras_push_val, rec_ras_val;
    logic [IW-1:0] rec_ras_idx;

    always #5 clk = ~clk;

    brtgt_select #(.AW(AW), .IW(IW)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_pc(in_pc),
        .in_uncond(in_uncond), .in_call(in_call), .in_ret(in_ret), .in_direct(in_direct),
        .in_imm_off(in_imm_off), .dir_taken(dir_taken), .tb_hit(tb_hit),
        .tb_target(tb_target), .ras_top_val(ras_top_val), .ras_top_idx(ras_top_idx),
        .out_valid(out_valid), .out_taken(out_taken), .out_target(out_target),
        .ras_push(ras_push), .ras_push_val(ras_push_val), .ras_pop(ras_pop),
        .dir_fix(dir_fix), .rec_was_call(rec_was_call), .rec_pushed(rec_pushed),
        .rec_was_ret(rec_was_ret), .rec_used_ras(rec_used_ras),
        .rec_ras_idx(rec_ras_idx), .rec_ras_val(rec_ras_val)
    );

    int checks = 0, fails = 0, cycles = 0;
    bit done = 0;

    // expected values for the result due at the next falling edge
    bit e_valid, e_taken, e_push, e_pop, e_fix, e_call, e_pushed, e_ret, e_used;
    logic [AW-1:0] e_target, e_push_val, e_ras_val;
    logic [IW-1:0] e_idx;
    string e_tag;

    task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Reference model from the requirements
    task automatic model();
        bit tk;
        e_valid = in_valid;
        e_push_val = in_pc;
        e_taken = 0; e_push = 0; e_pop = 0; e_fix = 0; e_call = 0; e_pushed = 0;
        e_used = 0; e_idx = '0; e_ras_val = '0; e_ret = in_ret;
        e_target = in_pc + 32'd4;
        tk = in_uncond || dir_taken;
        if (!tk) begin
            e_tag = "R9";
        end else if (in_ret) begin
            e_tag = "R4"; e_taken = 1; e_target = ras_top_val; e_pop = 1; e_used = 1;
            e_idx = ras_top_idx; e_ras_val = ras_top_val;
        end else if (in_call && in_uncond && in_direct) begin
            e_tag = "R10"; e_taken = 1; e_target = in_pc + in_imm_off;
            e_push = 1; e_call = 1; e_pushed = 1;
        end else if (tb_hit) begin
            e_tag = in_call ? "R5" : (in_uncond && !dir_taken ? "R3" : "R6");
            e_taken = 1; e_target = tb_target;
            e_push = in_call; e_call = in_call; e_pushed = in_call;
        end else if (!in_call) begin
            e_tag = "R7"; e_fix = 1;
        end else if (!in_uncond) begin
            e_tag = "R8"; e_push = 1; e_pop = 1; e_call = 1;
        end else begin
            e_tag = "R11"; e_taken = 1; e_push = 1; e_call = 1; e_pushed = 1;
        end
    endtask

    task automatic compare();
        chk(e_valid ? e_tag : "R2", "out_valid", 64'(out_valid), 64'(e_valid));
        if (e_valid) begin
            chk(e_tag, "out_taken", 64'(out_taken), 64'(e_taken));
            chk(e_tag, "out_target", 64'(out_target), 64'(e_target));
            chk(e_tag, "ras_push", 64'(ras_push), 64'(e_push));
            chk(e_tag, "ras_pop", 64'(ras_pop), 64'(e_pop));
            chk(e_tag, "dir_fix", 64'(dir_fix), 64'(e_fix));
            if (e_push) chk(e_tag, "ras_push_val", 64'(ras_push_val), 64'(e_push_val));
            chk(e_tag, "rec_was_call", 64'(rec_was_call), 64'(e_call));
            chk(e_tag, "rec_pushed", 64'(rec_pushed), 64'(e_pushed));
            chk(e_tag, "rec_was_ret", 64'(rec_was_ret), 64'(e_ret));
            chk(e_tag, "rec_used_ras", 64'(rec_used_ras), 64'(e_used));
            if (e_used) begin
                chk(e_tag, "rec_ras_idx", 64'(rec_ras_idx), 64'(e_idx));
                chk(e_tag, "rec_ras_val", 64'(rec_ras_val), 64'(e_ras_val));
            end
        end else begin
            chk("R2", "idle strobes", 64'({ras_push, ras_pop, dir_fix}), 64'(0));
        end
    endtask

    // Present one branch (or idle) after a falling edge, then check it one edge later
    task automatic step(bit v, bit u, bit c, bit r, bit d, bit dt, bit h);
        in_valid = v; in_uncond = u; in_call = c; in_ret = r; in_direct = d;
        dir_taken = dt; tb_hit = h;
        in_pc = {$urandom() % 32'h0100_0000, 2'b00} & 32'hFFFF_FFFC;
        in_imm_off = $urandom() & 32'h0000_FFFC;
        tb_target = {$urandom()} & 32'hFFFF_FFFC;
        ras_top_val = {$urandom()} & 32'hFFFF_FFFC;
        ras_top_idx = IW'($urandom());
        model();
        @(negedge clk);
        cycles++;
        compare();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    initial begin
        @(negedge clk);
        // R1: reset state
        @(negedge clk);
        chk("R1", "out_valid in reset", 64'(out_valid), 64'(0));
        chk("R1", "strobes in reset", 64'({ras_push, ras_pop, dir_fix}), 64'(0));
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "out_valid after reset", 64'(out_valid), 64'(0));
        chk("R1", "strobes after reset", 64'({ras_push, ras_pop, dir_fix}), 64'(0));
        // directed: v u c r d dt hit
        step(1, 0, 0, 0, 1, 0, 1);  // R9 not taken conditional
        step(1, 0, 0, 1, 0, 0, 0);  // R9 not-taken return keeps was_ret
        step(1, 1, 0, 0, 1, 0, 1);  // R3 unconditional overrides dir
        step(1, 0, 0, 1, 0, 1, 1);  // R4 taken return
        step(1, 1, 1, 1, 0, 0, 0);  // R4 return wins over call
        step(1, 0, 1, 0, 1, 1, 1);  // R5 conditional call hit
        step(1, 0, 0, 0, 1, 1, 1);  // R6 hit
        step(0, 0, 0, 0, 0, 0, 0);  // R2 idle
        step(1, 0, 0, 0, 1, 1, 0);  // R7 miss
        step(1, 1, 0, 0, 0, 0, 0);  // R7 unconditional plain miss
        step(1, 0, 1, 0, 1, 1, 0);  // R8 conditional call miss
        step(1, 1, 1, 0, 1, 0, 0);  // R10 immediate, miss
        step(1, 1, 1, 0, 1, 0, 1);  // R10 immediate, hit ignored
        step(1, 1, 1, 0, 0, 0, 0);  // R11 indirect unconditional call miss
        step(1, 1, 1, 0, 0, 0, 1);  // R5 indirect unconditional call hit
        step(0, 0, 0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0, 0, 0);
        for (int i = 0; i < 600; i++) begin
            int rv = $urandom();
            step(rv[0] | rv[1], rv[2], rv[3], rv[4] & rv[5], rv[6], rv[7], rv[8] | rv[9]);
        end
        step(0, 0, 0, 0, 0, 0, 0);
        finish_run();
    end

    initial begin
        repeat (5000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=%0d expected<5000", cycles);
        finish_run();
    end
endmodule